// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the network layer of a 1-Wire slave that owns one 64-bit identity. It sits between a bit-level slot engine and a memory-command layer. The slot engine reports each bit the master writes (`rx_vld_i`/`rx_bit_i`), marks each finished read slot (`tx_done_i`) and reports each reset pulse on the line (`bus_rst_i`, qualified by `rst_long_i` for a regular-length reset). The block answers with the bit to drive in the next read slot (`tx_bit_o`, valid while `tx_en_o` is high). It tells the slot engine which speed to use (`od_o`). It raises `selected_o` when the memory layer may take over.

After each bus reset the block collects an 8-bit command and runs one of six ROM functions: reading the identity, matching it, the bitwise search arbitration, skipping addressing, and two variants of skip and match that switch the device to overdrive speed. The identity is a 56-bit parameter (family code in the low byte, serial number above it). The block computes the checking byte itself and appends it as the top byte.

Top module: `onewire_rom_layer`

## Requirements
- R1: After `rst_ni` is released, `od_o`, `tx_en_o` and `selected_o` are 0 and `tx_bit_o` is 1. The block ignores all bits until the first `bus_rst_i`. After every bus reset, the next 8 received bits form the command, least significant bit first.
- R2: Command 33h drives the 64 identity bits in 64 read slots, bit 0 (family code LSB) first and bit 63 last, in true form. `selected_o` then pulses one cycle after the last slot.
- R3: Identity bits 63:56 hold the CRC of bits 55:0 (polynomial x^8+x^5+x^4+1, zero start, LSB first). Running the same CRC over all 64 bits therefore ends at zero.
- R4: Command 55h followed by 64 received bits that equal the identity makes `selected_o` pulse one cycle after the last bit, and at no earlier point.
- R5: On the first Match bit that differs from the identity, the block goes quiet until the next bus reset. `tx_en_o` stays 0, `tx_bit_o` stays 1, further bits are ignored and no `selected_o` pulse follows.
- R6: Command F0h runs, for each identity bit k from 0 to 63, a read slot carrying bit k, a read slot carrying its complement and a received direction bit. When all 64 directions equal the identity, `selected_o` pulses.
- R7: A Search direction bit that differs from identity bit k drops the device out. From the next cycle it drives nothing and raises no `selected_o` until the next bus reset.
- R8: Command CCh pulses `selected_o` one cycle after its 8th bit and leaves `od_o` unchanged.
- R9: Command 3Ch sets `od_o` and pulses `selected_o` one cycle after its 8th bit.
- R10: Command 69h sets `od_o` one cycle after its 8th bit. When the following 64 bits equal the identity, `od_o` stays 1 and `selected_o` pulses.
- R11: On an Overdrive Match mismatch, `od_o` returns to the value it had before the 69h command. A device already in overdrive stays there. Any other device goes back to regular speed.
- R12: A bus reset with `rst_long_i` high clears `od_o`, and one with `rst_long_i` low keeps it. Either kind aborts any command in progress, stops driving and restarts command reception.
- R13: An unrecognised command code makes the block quiet (no driving, no `selected_o`) until the next bus reset.
- R14: `selected_o` is never high for two cycles in a row, and `tx_bit_o` is 1 whenever `tx_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | One-cycle pulse: reset pulse seen on the line |
| rst_long_i | input | 1 | With `bus_rst_i`: the reset had regular-speed length |
| rx_vld_i | input | 1 | One-cycle pulse: a master write slot finished |
| rx_bit_i | input | 1 | Bit value of that write slot |
| tx_done_i | input | 1 | One-cycle pulse: a master read slot finished |
| tx_en_o | output | 1 | Block drives read slots with `tx_bit_o` |
| tx_bit_o | output | 1 | Bit for the next read slot (1 = release) |
| od_o | output | 1 | Overdrive speed flag |
| selected_o | output | 1 | One-cycle pulse: control passes to the memory layer |

## Verification
The hardest state to reach is an Overdrive Match mismatch on a device that is already in overdrive. To get there, the device must first enter overdrive through Overdrive Skip and then see only a short reset, so the flag survives into the next 69h command. The stimulus builds this prefix on purpose. It also mixes random choices of prior speed and random mismatch positions in the 64 match bits. Search dropouts are driven the same way: the wrong direction is placed at a random bit, including the final one. The bench then probes read slots afterwards to show the device has gone silent.

// File: rtl/onew_rom_pkg.sv
package onew_rom_pkg;

  typedef enum logic [2:0] {
    ST_WAIT, ST_CMD, ST_READ, ST_MATCH, ST_S_BIT, ST_S_CMP, ST_S_DIR, ST_DONE
  } rom_st_e;

  localparam logic [7:0] CMD_READ     = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;

  // reflected x^8+x^5+x^4+1, lsb first, zero start
  function automatic logic [7:0] id_crc8(input logic [55:0] body);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ body[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/onew_cmd_rx.sv
module onew_cmd_rx #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          bit_vld_i,
  input  logic          bit_i,
  output logic          done_o,
  output logic [CW-1:0] code_o
);
  localparam int NW = $clog2(CW);

  logic [CW-2:0] sh_q;
  logic [NW-1:0] cnt_q;
  logic          take;

  assign take   = en_i & bit_vld_i & ~clr_i;
  assign done_o = take && (cnt_q == NW'(CW - 1));
  assign code_o = {bit_i, sh_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= code_o[CW-1:1];
      cnt_q <= done_o ? '0 : cnt_q + NW'(1);
    end
  end

  AST_CMD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !done_o) |=> (cnt_q == $past(cnt_q) + NW'(1))); // R1

endmodule

// File: rtl/onew_id_ptr.sv
module onew_id_ptr #(
  parameter int             IDW = 64,
  parameter logic [IDW-1:0] ID  = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o,
  output logic bit_o
);
  localparam int IW = $clog2(IDW);

  logic [IW-1:0] idx_q;

  assign last_o = (idx_q == IW'(IDW - 1));
  assign bit_o  = ID[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= last_o ? '0 : idx_q + IW'(1);
  end

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !last_o) |=> (idx_q == $past(idx_q) + IW'(1))); // R2

endmodule

// File: rtl/onew_speed.sv
module onew_speed (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic arm_i,
  input  logic restore_i,
  output logic od_o
);
  logic od_q, saved_q;

  assign od_o = od_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      od_q    <= 1'b0;
      saved_q <= 1'b0;
    end else if (clr_i) begin
      od_q    <= 1'b0;
    end else if (arm_i) begin
      saved_q <= od_q;
      od_q    <= 1'b1;
    end else if (set_i) begin
      od_q    <= 1'b1;
    end else if (restore_i) begin
      od_q    <= saved_q;
    end
  end

  AST_OD_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !clr_i) |=> od_o); // R10

endmodule

// File: rtl/onewire_rom_layer.sv
module onewire_rom_layer
  import onew_rom_pkg::*;
#(
  parameter logic [55:0] ID_BODY = 56'h9E2D71C408B63B,
  parameter int          CMD_W   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic rst_long_i,
  input  logic rx_vld_i,
  input  logic rx_bit_i,
  input  logic tx_done_i,
  output logic tx_en_o,
  output logic tx_bit_o,
  output logic od_o,
  output logic selected_o
);
  localparam int         ID_W    = 64;
  localparam logic [63:0] ID_FULL = {id_crc8(ID_BODY), ID_BODY};

  rom_st_e          state_q, state_d;
  logic             odm_q, odm_d;
  logic             sel_d;
  logic             cmd_done;
  logic [CMD_W-1:0] cmd_code;
  logic             id_last, id_bit, bit_ok, step;
  logic             arm, set_od, restore;

  onew_cmd_rx #(.CW(CMD_W)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(bus_rst_i),
    .en_i(state_q == ST_CMD), .bit_vld_i(rx_vld_i), .bit_i(rx_bit_i),
    .done_o(cmd_done), .code_o(cmd_code)
  );

  onew_id_ptr #(.IDW(ID_W), .ID(ID_FULL)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(bus_rst_i | cmd_done),
    .step_i(step), .last_o(id_last), .bit_o(id_bit)
  );

  onew_speed u_spd (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(bus_rst_i & rst_long_i),
    .set_i(set_od & ~bus_rst_i), .arm_i(arm & ~bus_rst_i),
    .restore_i(restore & ~bus_rst_i), .od_o(od_o)
  );

  assign bit_ok = (rx_bit_i == id_bit);
  assign step   = ((state_q == ST_READ) & tx_done_i)
                | (((state_q == ST_MATCH) | (state_q == ST_S_DIR)) & rx_vld_i & bit_ok);

  always_comb begin
    state_d = state_q;
    odm_d   = odm_q;
    sel_d   = 1'b0;
    arm     = 1'b0;
    set_od  = 1'b0;
    restore = 1'b0;
    unique case (state_q)
      ST_CMD: if (cmd_done) begin
        case (cmd_code)
          CMD_READ:     state_d = ST_READ;
          CMD_MATCH:    begin state_d = ST_MATCH; odm_d = 1'b0; end
          CMD_OD_MATCH: begin state_d = ST_MATCH; odm_d = 1'b1; arm = 1'b1; end
          CMD_SEARCH:   state_d = ST_S_BIT;
          CMD_SKIP:     begin state_d = ST_DONE; sel_d = 1'b1; end
          CMD_OD_SKIP:  begin state_d = ST_DONE; sel_d = 1'b1; set_od = 1'b1; end
          default:      state_d = ST_WAIT;
        endcase
      end
      ST_READ: if (tx_done_i && id_last) begin
        state_d = ST_DONE;
        sel_d   = 1'b1;
      end
      ST_MATCH: if (rx_vld_i) begin
        if (!bit_ok) begin
          state_d = ST_WAIT;
          restore = odm_q;
        end else if (id_last) begin
          state_d = ST_DONE;
          sel_d   = 1'b1;
        end
      end
      ST_S_BIT: if (tx_done_i) state_d = ST_S_CMP;
      ST_S_CMP: if (tx_done_i) state_d = ST_S_DIR;
      ST_S_DIR: if (rx_vld_i) begin
        if (!bit_ok)      state_d = ST_WAIT;
        else if (id_last) begin state_d = ST_DONE; sel_d = 1'b1; end
        else              state_d = ST_S_BIT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT;
      odm_q      <= 1'b0;
      selected_o <= 1'b0;
    end else if (bus_rst_i) begin
      state_q    <= ST_CMD;
      selected_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      odm_q      <= odm_d;
      selected_o <= sel_d;
    end
  end

  assign tx_en_o  = (state_q == ST_READ) | (state_q == ST_S_BIT) | (state_q == ST_S_CMP);
  assign tx_bit_o = ~tx_en_o | (id_bit ^ (state_q == ST_S_CMP));

  AST_SEL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selected_o |=> !selected_o); // R14

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (!tx_en_o && !selected_o)); // R12

  AST_LONG_RST_OD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && rst_long_i) |=> !od_o); // R12

  AST_ODSKIP_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done && cmd_code == CMD_OD_SKIP) |=> (od_o && selected_o)); // R9

  AST_MATCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i && state_q == ST_MATCH && !bit_ok && !bus_rst_i) |=> (!tx_en_o && !selected_o)); // R5

endmodule

// File: tb/tb_onewire_rom_layer.sv
`timescale 1ns/1ps
module tb_onewire_rom_layer;
  localparam logic [55:0] BODY = 56'h9E2D71C408B63B;

  function automatic logic [7:0] crc_tb(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic f;
      f = c[0] ^ v[i];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  localparam logic [63:0] ID = {crc_tb({8'h00, BODY}, 56), BODY};

  logic clk = 0, rst_n = 0;
  logic bus_rst = 0, rst_long = 0, rx_vld = 0, rx_bit = 0, tx_done = 0;
  logic tx_en, tx_bit, od, sel;
  int vectors = 0, errors = 0, sel_cnt = 0, cyc = 0;

  always #10 clk = ~clk;

  onewire_rom_layer #(.ID_BODY(BODY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .rst_long_i(rst_long),
    .rx_vld_i(rx_vld), .rx_bit_i(rx_bit), .tx_done_i(tx_done),
    .tx_en_o(tx_en), .tx_bit_o(tx_bit), .od_o(od), .selected_o(sel)
  );

  always @(negedge clk) if (sel) sel_cnt++;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wbit(input logic b);
    @(negedge clk); rx_vld = 1; rx_bit = b;
    @(negedge clk); rx_vld = 0;
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wbit(v[i]);
  endtask

  task automatic rbit(output logic en, output logic b);
    @(negedge clk); en = tx_en; b = tx_bit; tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic breset(input logic lng);
    @(negedge clk); bus_rst = 1; rst_long = lng;
    @(negedge clk); bus_rst = 0; rst_long = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet(input string req);
    logic en, b;
    rbit(en, b);
    chk({req, " quiet en/bit"}, {62'd0, en, b}, 64'd1);
  endtask

  task automatic read_run();
    logic [63:0] got;
    logic en, b;
    int s0, bad;
    s0 = sel_cnt; bad = 0;
    wbyte(8'h33);
    for (int k = 0; k < 64; k++) begin
      rbit(en, b);
      got[k] = b;
      if (!en) bad++;
    end
    settle();
    chk("R2 read identity", got, ID);
    chk("R2 read driven", bad, 0);
    chk("R2 read selected", sel_cnt - s0, 1);
    chk("R3 crc over 64", crc_tb(got, 64), 0);
  endtask

  task automatic match_run(input logic [7:0] code, input int flip, input logic od_exp_end);
    int s0, early;
    s0 = sel_cnt; early = 0;
    wbyte(code);
    if (code == 8'h69) chk("R10 od after 69h", od, 1);
    for (int k = 0; k < 64; k++) begin
      if (k == 63 && sel_cnt != s0) early++;
      wbit(k == flip ? ~ID[k] : ID[k]);
    end
    settle();
    chk(flip < 0 ? "R4 match selected" : "R5 mismatch no select", sel_cnt - s0, flip < 0 ? 1 : 0);
    chk("R4 no early select", early, 0);
    if (code == 8'h69) chk(flip < 0 ? "R10 od kept" : "R11 od restored", od, od_exp_end);
    quiet(flip < 0 ? "R4" : "R5");
  endtask

  task automatic search_run(input int flip);
    logic en, b;
    int s0, bad;
    s0 = sel_cnt; bad = 0;
    wbyte(8'hF0);
    for (int k = 0; k < 64; k++) begin
      rbit(en, b);
      if (!en || b != ID[k]) bad++;
      rbit(en, b);
      if (!en || b != ~ID[k]) bad++;
      if (k == flip) begin
        wbit(~ID[k]);
        break;
      end
      wbit(ID[k]);
    end
    settle();
    chk("R6 search bit/complement", bad, 0);
    chk(flip < 0 ? "R6 search selected" : "R7 dropout no select", sel_cnt - s0, flip < 0 ? 1 : 0);
    quiet(flip < 0 ? "R6" : "R7");
  endtask

  function automatic bit known(input logic [7:0] c);
    return c == 8'h33 || c == 8'h55 || c == 8'hF0 || c == 8'hCC || c == 8'h3C || c == 8'h69;
  endfunction

  task automatic unknown_run(input logic [7:0] c);
    int s0;
    s0 = sel_cnt;
    wbyte(c);
    for (int i = 0; i < 16; i++) wbit(i[0]);
    settle();
    chk("R13 unknown no select", sel_cnt - s0, 0);
    quiet("R13");
  endtask

  initial begin
    cyc = 0;
    wait (cyc >= 150000);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int s0, r, flip;
    logic [7:0] c;
    logic pre;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {60'd0, od, tx_en, sel, tx_bit}, 64'd1);
    rst_n = 1;
    @(negedge clk);
    // R1: nothing before first bus reset
    s0 = sel_cnt;
    wbyte(8'hCC);
    settle();
    chk("R1 ignored before bus reset", sel_cnt - s0, 0);
    quiet("R1");

    breset(1); read_run();
    breset(1); s0 = sel_cnt; wbyte(8'hCC); settle();
    chk("R8 skip selected", sel_cnt - s0, 1);
    chk("R8 skip od", od, 0);
    breset(1); match_run(8'h55, -1, 0);
    breset(1); match_run(8'h55, 0, 0);
    breset(1); match_run(8'h55, 63, 0);
    breset(1); search_run(-1);
    breset(1); search_run(0);
    breset(1); search_run(63);
    breset(1); unknown_run(8'hA5);

    // overdrive paths
    breset(1); s0 = sel_cnt; wbyte(8'h3C); settle();
    chk("R9 od skip sets od", od, 1);
    chk("R9 od skip selected", sel_cnt - s0, 1);
    breset(0);
    chk("R12 short reset keeps od", od, 1);
    match_run(8'h69, -1, 1);
    breset(0); match_run(8'h69, 17, 1);
    breset(1);
    chk("R12 long reset clears od", od, 0);
    match_run(8'h69, 40, 0);

    // abort mid-read
    breset(1); wbyte(8'h33);
    for (int k = 0; k < 10; k++) begin logic e, b; rbit(e, b); end
    breset(0);
    chk("R12 abort stops driving", tx_en, 0);
    s0 = sel_cnt; wbyte(8'hCC); settle();
    chk("R12 restart after abort", sel_cnt - s0, 1);

    for (int it = 0; it < 24; it++) begin
      flip = $urandom_range(0, 90);
      if (flip > 63) flip = -1;
      case ($urandom_range(0, 4))
        0: begin breset(1); match_run(8'h55, flip, 0); end
        1: begin breset(1); search_run(flip); end
        2: begin
          do c = 8'($urandom); while (known(c));
          breset(1); unknown_run(c);
        end
        3: begin breset(1); read_run(); end
        default: begin
          pre = 1'($urandom_range(0, 1));
          breset(1);
          if (pre) begin wbyte(8'h3C); breset(0); end
          match_run(8'h69, flip, flip < 0 ? 1'b1 : pre);
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule